// File: doc/BRIEF.md
# Programmable Escape Clock Generator

This block derives the low-power escape clock of a serial display link from a faster functional clock. Software sets a 13-bit divide value N and an enable. While the enable is high, the block produces three outputs. The first is a divided clock level that is high for ceil(N/2) functional cycles and low for floor(N/2) cycles. The second is a one-cycle tick on the last cycle of every escape period. The third is a pad-facing toggle that flips once per period, so it runs at half the escape rate. The divisor is chosen so that the escape clock falls between 32 kHz and 20 MHz for the functional clock in use.

The block also holds the configuration bit that keeps the high-speed clock lane running continuously. That bit may only change while the link interface is disabled. A write that arrives while the interface runs is discarded and raises a sticky error flag. Software clears the flag by writing a one to it.

Top module: `escclk_gen`

## Requirements
- R1: After reset, escLevel, escTick, padToggle, contClk and wrErr are all 0.
- R2: With divisor N in 1..8191 and escEn high, every escape period lasts N functional cycles. escLevel is 1 for the first ceil(N/2) cycles of the period and 0 for the remaining floor(N/2) cycles. escTick is 1 only on the last cycle of each period.
- R3: A divisor value of 0 behaves as 1. escTick is then 1 on every cycle and escLevel stays 1.
- R4: The divisor is sampled only when a period starts. A change during a running period takes effect only from the following period.
- R5: The first clock edge that sees escEn high starts a period, so escLevel is 1 in the next cycle. One edge after escEn goes low, escLevel, escTick and padToggle are all 0 and the counter restarts.
- R6: While escEn is low, the divisor input has no effect and all three clock outputs remain 0.
- R7: padToggle inverts on the clock edge that ends each period, which gives a pad period of 2N cycles.
- R8: A one-cycle cfgWr pulse while ifEn is 0 loads cfgWrData into contClk, visible in the next cycle.
- R9: A cfgWr pulse while ifEn is 1 leaves contClk unchanged and sets wrErr. errClr pulsed high clears wrErr. If a set and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| escEn | input | 1 | Escape clock enable |
| divisor | input | 13 | Divide value N (0 treated as 1) |
| ifEn | input | 1 | Link interface enabled; locks contClk |
| cfgWr | input | 1 | Write strobe for the continuous-clock bit |
| cfgWrData | input | 1 | Value written to the continuous-clock bit |
| errClr | input | 1 | Write-one-to-clear for wrErr |
| escLevel | output | 1 | Divided escape clock level |
| escTick | output | 1 | One-cycle pulse on the last cycle of each period |
| padToggle | output | 1 | Half-rate toggle, flips once per period |
| contClk | output | 1 | Continuous high-speed clock lane setting |
| wrErr | output | 1 | Sticky flag for a write dropped by the lock |

## Verification
If the internal counter or the latched divisor is wrong, the ports show it within one escape period. The tick spacing, the high time or the pad toggle edges move away from N, ceil(N/2) and the tick edge. A divisor captured at the wrong moment shows up as a wrong length in the period that follows the change. A faulty disable path shows up as a non-zero output one cycle after escEn falls. A faulty lock shows up in contClk or wrErr in the cycle after the write.

// File: rtl/escclk_pkg.sv
package escclk_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic start;  // first edge with enable high
    logic wrap;   // end of period: reload divisor, flip pad
    logic clear;  // enable low: synchronous restart
  } dpStrobes_t;
endpackage

// File: rtl/escclk_ctrl.sv
module escclk_ctrl
  import escclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       escEn,
  input  logic       periodEnd,
  output logic       running,
  output dpStrobes_t strb
);

  logic runReg;

  always_ff @(posedge clk) begin
    if (!rstN) runReg <= 1'b0;
    else       runReg <= escEn;
  end

  assign running = runReg;

  always_comb begin
    strb.clear = !escEn;
    strb.start = escEn && !runReg;
    strb.wrap  = escEn && runReg && periodEnd;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clear, strb.start, strb.wrap})); // R5

  AST_RUN_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> running); // R5

endmodule

// File: rtl/escclk_dp.sv
module escclk_dp
  import escclk_pkg::*;
#(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             running,
  input  dpStrobes_t       strb,
  input  logic [DIV_W-1:0] divisor,
  output logic             periodEnd,
  output logic             levelOut,
  output logic             padOut
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] curDiv;
  logic             padReg;
  logic [DIV_W-1:0] divEff;
  logic [DIV_W:0]   highLen;

  assign divEff  = (divisor == '0) ? ONE : divisor;
  assign highLen = ({1'b0, curDiv} + (DIV_W+1)'(1)) >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      curDiv <= ONE;
      padReg <= 1'b0;
    end else if (strb.clear) begin
      cnt    <= '0;
      curDiv <= ONE;
      padReg <= 1'b0;
    end else if (strb.start) begin
      cnt    <= '0;
      curDiv <= divEff;
    end else if (strb.wrap) begin
      cnt    <= '0;
      curDiv <= divEff;
      padReg <= ~padReg;
    end else if (running) begin
      cnt    <= cnt + ONE;
    end
  end

  assign periodEnd = running && (cnt == curDiv - ONE);
  assign levelOut  = running && ({1'b0, cnt} < highLen);
  assign padOut    = padReg;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < curDiv)); // R2

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    curDiv != '0); // R3

  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (running && !strb.wrap && !strb.clear) |=> $stable(curDiv)); // R4

  AST_PAD_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> (padReg != $past(padReg))); // R7

endmodule

// File: rtl/escclk_cfg.sv
module escclk_cfg (
  input  logic clk,
  input  logic rstN,
  input  logic ifEn,
  input  logic cfgWr,
  input  logic cfgWrData,
  input  logic errClr,
  output logic contClk,
  output logic wrErr
);

  logic contReg;
  logic errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      contReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      if (cfgWr && !ifEn) contReg <= cfgWrData;
      if (cfgWr && ifEn)  errReg  <= 1'b1;
      else if (errClr)    errReg  <= 1'b0;
    end
  end

  assign contClk = contReg;
  assign wrErr   = errReg;

  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    ifEn |=> $stable(contClk)); // R9

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && ifEn) |=> wrErr); // R9

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !ifEn) |=> (contClk == $past(cfgWrData))); // R8

endmodule

// File: rtl/escclk_gen.sv
module escclk_gen
  import escclk_pkg::*;
#(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             escEn,
  input  logic [DIV_W-1:0] divisor,
  input  logic             ifEn,
  input  logic             cfgWr,
  input  logic             cfgWrData,
  input  logic             errClr,
  output logic             escLevel,
  output logic             escTick,
  output logic             padToggle,
  output logic             contClk,
  output logic             wrErr
);

  dpStrobes_t strb;
  logic       running;
  logic       periodEnd;

  escclk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .escEn     (escEn),
    .periodEnd (periodEnd),
    .running   (running),
    .strb      (strb)
  );

  escclk_dp #(.DIV_W(DIV_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .running   (running),
    .strb      (strb),
    .divisor   (divisor),
    .periodEnd (periodEnd),
    .levelOut  (escLevel),
    .padOut    (padToggle)
  );

  assign escTick = periodEnd;

  escclk_cfg u_cfg (
    .clk       (clk),
    .rstN      (rstN),
    .ifEn      (ifEn),
    .cfgWr     (cfgWr),
    .cfgWrData (cfgWrData),
    .errClr    (errClr),
    .contClk   (contClk),
    .wrErr     (wrErr)
  );

  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !escEn |=> (!escLevel && !escTick && !padToggle)); // R5

  AST_TICK_ENDS_HIGH_OR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (escTick && escEn) |=> escLevel); // R2

endmodule

// File: tb/escclk_gen_test.sv
module escclk_gen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        escEn = 1'b0;
  logic [12:0] divisor = '0;
  logic        ifEn = 1'b0;
  logic        cfgWr = 1'b0;
  logic        cfgWrData = 1'b0;
  logic        errClr = 1'b0;
  logic        escLevel, escTick, padToggle, contClk, wrErr;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  escclk_gen uut (
    .clk(clk), .rstN(rstN), .escEn(escEn), .divisor(divisor),
    .ifEn(ifEn), .cfgWr(cfgWr), .cfgWrData(cfgWrData), .errClr(errClr),
    .escLevel(escLevel), .escTick(escTick), .padToggle(padToggle),
    .contClk(contClk), .wrErr(wrErr)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<190000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effDiv(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int highOf(input int n);
    return (n + 1) / 2;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic waitTick();
    int guard = 0;
    do begin step(); guard++; end while (!escTick && guard < 20000);
  endtask

  // called right after a sample with escTick==1; counts the next period
  task automatic measure(input int n, input string req);
    int len = 0;
    int high = 0;
    int padBad = 0;
    bit prevTick = 1'b1;
    logic prevPad = padToggle;
    do begin
      step();
      len++;
      if (escLevel) high++;
      if (prevTick ? (padToggle == prevPad) : (padToggle != prevPad)) padBad++;
      prevTick = escTick;
      prevPad = padToggle;
    end while (!escTick && len < 20000);
    check(len == n, {req, " period"}, len, n);
    check(high == highOf(n), {req, " high time"}, high, highOf(n));
    check(padBad == 0, "R7 pad toggle edges", padBad, 0);
  endtask

  task automatic runDiv(input int d, input string req);
    escEn = 1'b0; divisor = 13'(d);
    step();
    escEn = 1'b1;
    step();
    check(escLevel == 1'b1, "R5 level high after enable", escLevel, 1);
    waitTick();
    measure(effDiv(d), req);
    measure(effDiv(d), req);
  endtask

  initial begin
    int quiet;
    int len;
    void'($urandom(32'd4242));

    // R1 reset state
    step(); step();
    check({escLevel, escTick, padToggle, contClk, wrErr} == 5'b0, "R1 reset outputs",
          {escLevel, escTick, padToggle, contClk, wrErr}, 0);
    rstN = 1'b1;

    // R6 divisor ignored while disabled
    quiet = 0;
    for (int i = 0; i < 20; i++) begin
      divisor = 13'($urandom);
      step();
      if (escLevel || escTick || padToggle) quiet++;
    end
    check(quiet == 0, "R6 outputs quiet while disabled", quiet, 0);

    // R2 directed divisors
    runDiv(1, "R2 div1");
    runDiv(2, "R2 div2");
    runDiv(3, "R2 div3");
    runDiv(8, "R2 div8");

    // R5 disable clears outputs one edge later
    escEn = 1'b0;
    step();
    check({escLevel, escTick, padToggle} == 3'b0, "R5 disable clears",
          {escLevel, escTick, padToggle}, 0);

    // R3 divisor zero acts as one
    runDiv(0, "R3 div0");
    quiet = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (!escLevel || !escTick) quiet++;
    end
    check(quiet == 0, "R3 tick and level every cycle", quiet, 0);

    // R2 maximum divisor
    runDiv(8191, "R2 div8191");

    // R4 mid-period change
    runDiv(8, "R4 setup");
    len = 0;
    do begin
      step(); len++;
      if (len == 2) divisor = 13'd4;
    end while (!escTick && len < 100);
    check(len == 8, "R4 running period kept", len, 8);
    measure(4, "R4 new divisor next period");

    // R2 random divisors
    for (int i = 0; i < 30; i++) begin
      int d = $urandom_range(1, 64);
      runDiv(d, "R2 random");
    end
    escEn = 1'b0;
    step();

    // R8 write while interface off
    ifEn = 1'b0; cfgWr = 1'b1; cfgWrData = 1'b1;
    step(); cfgWr = 1'b0;
    check(contClk == 1'b1, "R8 write accepted", contClk, 1);
    check(wrErr == 1'b0, "R8 no error", wrErr, 0);

    // R9 write while interface on
    ifEn = 1'b1; cfgWr = 1'b1; cfgWrData = 1'b0;
    step(); cfgWr = 1'b0;
    check(contClk == 1'b1, "R9 write dropped", contClk, 1);
    check(wrErr == 1'b1, "R9 error set", wrErr, 1);
    step();
    check(wrErr == 1'b1, "R9 error sticky", wrErr, 1);
    errClr = 1'b1;
    step(); errClr = 1'b0;
    check(wrErr == 1'b0, "R9 error cleared", wrErr, 0);
    cfgWr = 1'b1; errClr = 1'b1;
    step(); cfgWr = 1'b0; errClr = 1'b0;
    check(wrErr == 1'b1, "R9 set wins over clear", wrErr, 1);

    ifEn = 1'b0; cfgWr = 1'b1; cfgWrData = 1'b0;
    step(); cfgWr = 1'b0;
    check(contClk == 1'b0, "R8 write zero accepted", contClk, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule